// File: doc/BRIEF.md
# Single-Precision Result Packer

This block turns an unpacked floating-point result into a 32-bit IEEE-754 single-precision word. The unpacked form carries a class (zero, finite number, infinity or NaN), a sign, an unbiased exponent, and a 26-bit mantissa. The mantissa holds an explicit leading one, 23 fraction bits, a guard bit and a round bit. A separate sticky bit travels with it. The caller also supplies the rounding mode in force and the underflow-trap-enable bit.

Finite numbers are rounded to 24 significant bits. A number that is too small for the normal range is first shifted right into subnormal form, and the bits it loses fold into sticky before rounding. A number that is too large either saturates to the largest finite value or becomes infinity, depending on the mode and the sign. The packer also raises overflow, underflow and inexact flags for each result. It is a single registered stage, so the packed word and its flags appear one cycle after the valid input.

Top module: `sp_packer`

## Requirements
- R1: `out_valid` is `in_valid` delayed by one clock. The word and flags of an accepted input appear on that cycle. All three flags are 0 on any cycle where `out_valid` is 0. Reset clears `out_valid`, `out_word` and the flags.
- R2: Encodings. `in_class` is 0 for zero, 1 for a finite number, 2 for infinity and 3 for NaN. `rnd_mode` is 0 for nearest-even, 1 for toward zero, 2 for toward +infinity and 3 for toward -infinity. `in_mant` bit 25 is the leading one, bits 24:2 are the fraction, bit 1 is guard and bit 0 is round. For example, a number with exponent 0 and mantissa 0x2000000 packs to 0x3F800000.
- R3: A zero packs to the sign bit alone. An infinity packs to the sign, exponent field 255 and fraction 0. Neither raises any flag.
- R4: A NaN packs to the sign, exponent field 255 and fraction `in_mant[24:2]`, and raises no flag.
- R5: A finite number whose biased exponent (exponent + 127) is in 1..254 has its 24-bit significand `in_mant[25:2]` rounded by the selected mode, using guard, round and sticky. Nearest-even breaks an exact halfway case toward an even result. Inexact is raised exactly when guard, round or sticky (after any subnormal shift) is set.
- R6: When rounding carries a normal significand to 2.0, the exponent field is one higher than the biased exponent and the fraction is 0.
- R7: If a normal number's final biased exponent is 255 or more, it overflows. The result is infinity with the overflow flag set in nearest mode, toward +infinity when positive, and toward -infinity when negative. In every other case the result is the sign with 0x7F7FFFFF and no overflow flag.
- R8: A finite number with biased exponent b <= 0 is shifted right by 1-b, with every bit shifted out ORed into sticky. It is then rounded to 23 fraction bits and packed with exponent field 0.
- R9: A subnormal that rounds up to 2^23 packs as the smallest normal (exponent field 1, fraction 0) and raises no underflow.
- R10: A subnormal that stays subnormal raises underflow when the rounding was inexact or `uf_trap_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input result is present this cycle |
| in_class | input | 2 | Value class (R2 encoding) |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 10 | Unbiased exponent, two's complement |
| in_mant | input | 26 | Leading one, fraction, guard, round |
| in_sticky | input | 1 | OR of all lower discarded bits |
| rnd_mode | input | 2 | Rounding mode (R2 encoding) |
| uf_trap_en | input | 1 | Underflow trap enabled |
| out_valid | output | 1 | Packed word valid |
| out_word | output | 32 | Packed single-precision word |
| out_ovf | output | 1 | Overflow to infinity |
| out_unf | output | 1 | Underflow |
| out_inx | output | 1 | Inexact |

## Verification
The hardest case to reach is the boundary between subnormal and normal. At that boundary, a value that starts subnormal rounds up into the smallest normal. The same edge governs whether the underflow flag appears through inexactness alone or only because the trap is enabled. The stimulus sweeps every unbiased exponent from -155 to -120, together with a few far-out exponents. At each exponent it crosses three high mantissa patterns (all ones, leading one only, alternating bits) with all 16 guard/round/low-bit combinations, both sticky values, all four modes, both signs and both trap settings. The all-ones pattern near exponent -127 forces the carry into the normal range. The same pattern at exponent 127 forces the exponent bump into overflow.

// File: rtl/fpk_pkg.sv
package fpk_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NUM  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } num_class_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  // True when an overflowing value of this sign must become infinity
  function automatic logic ovf_to_inf(input rmode_e mode, input logic sign);
    case (mode)
      RM_NEAR: return 1'b1;
      RM_ZERO: return 1'b0;
      RM_UP:   return ~sign;
      default: return sign;
    endcase
  endfunction

endpackage

// File: rtl/fpk_shr.sv
// Right shifter that folds every bit shifted out into a sticky bit.
module fpk_shr #(
  parameter int W    = 26,
  parameter int SH_W = 5
) (
  input  logic [W-1:0]    in_bits,
  input  logic            in_sticky,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    out_bits,
  output logic            out_sticky
);

  logic [W-1:0] stage_bits [0:SH_W];
  logic         stage_stk  [0:SH_W];

  assign stage_bits[0] = in_bits;
  assign stage_stk[0]  = in_sticky;

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    localparam int STEP = 2 ** i;
    localparam logic [W-1:0] DROP =
      (STEP >= W) ? {W{1'b1}} : W'((64'd1 << STEP) - 64'd1);

    assign stage_bits[i+1] = amt[i] ? (stage_bits[i] >> STEP) : stage_bits[i];
    assign stage_stk[i+1]  = stage_stk[i] | (amt[i] & (|(stage_bits[i] & DROP)));
  end

  assign out_bits   = stage_bits[SH_W];
  assign out_sticky = stage_stk[SH_W];

endmodule

// File: rtl/fpk_round.sv
// Rounds a W-bit significand using guard, round and sticky.
module fpk_round
  import fpk_pkg::*;
#(
  parameter int W = 24
) (
  input  logic [W-1:0] val,
  input  logic         guard,
  input  logic         rbit,
  input  logic         sticky,
  input  logic [1:0]   mode,
  input  logic         sign,
  output logic [W:0]   rounded,
  output logic         inexact,
  output logic         bumped
);

  rmode_e md;
  assign md      = rmode_e'(mode);
  assign inexact = guard | rbit | sticky;

  always_comb begin
    case (md)
      RM_NEAR: bumped = guard & (rbit | sticky | val[0]);
      RM_ZERO: bumped = 1'b0;
      RM_UP:   bumped = inexact & ~sign;
      default: bumped = inexact & sign;
    endcase
  end

  assign rounded = {1'b0, val} + (W+1)'(bumped);

endmodule

// File: rtl/sp_packer.sv
module sp_packer
  import fpk_pkg::*;
#(
  parameter int EXP_IN_W = 10,
  parameter int FRAC_W   = 23,
  parameter int EXPF_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [1:0]                   in_class,
  input  logic                         in_sign,
  input  logic signed [EXP_IN_W-1:0]   in_exp,
  input  logic [FRAC_W+2:0]            in_mant,
  input  logic                         in_sticky,
  input  logic [1:0]                   rnd_mode,
  input  logic                         uf_trap_en,
  output logic                         out_valid,
  output logic [FRAC_W+EXPF_W:0]       out_word,
  output logic                         out_ovf,
  output logic                         out_unf,
  output logic                         out_inx
);

  localparam int SIG_W    = FRAC_W + 1;
  localparam int MANT_W   = FRAC_W + 3;
  localparam int WORD_W   = FRAC_W + EXPF_W + 1;
  localparam int BIAS     = 2 ** (EXPF_W - 1) - 1;
  localparam int EXP_ONES = 2 ** EXPF_W - 1;
  localparam int SH_MAX   = MANT_W + 1;
  localparam int SH_W     = $clog2(SH_MAX + 1);
  localparam int BX_W     = ((EXP_IN_W > EXPF_W) ? EXP_IN_W : EXPF_W) + 2;

  num_class_e cls;
  rmode_e     md;
  assign cls = num_class_e'(in_class);
  assign md  = rmode_e'(rnd_mode);

  // Biased exponent and subnormal shift distance
  logic signed [BX_W-1:0] biased, deficit, exp_norm;
  logic                   is_sub;
  logic [SH_W-1:0]        shamt;

  assign biased  = $signed({{(BX_W-EXP_IN_W){in_exp[EXP_IN_W-1]}}, in_exp})
                 + $signed(BX_W'(BIAS));
  assign is_sub  = (biased <= 0);
  assign deficit = $signed(BX_W'(1)) - biased;

  always_comb begin
    if (!is_sub)
      shamt = '0;
    else if (deficit > $signed(BX_W'(SH_MAX)))
      shamt = SH_W'(SH_MAX);
    else
      shamt = deficit[SH_W-1:0];
  end

  logic [MANT_W-1:0] sh_bits;
  logic              sh_stk;

  fpk_shr #(.W(MANT_W), .SH_W(SH_W)) u_shr (
    .in_bits   (in_mant),
    .in_sticky (in_sticky),
    .amt       (shamt),
    .out_bits  (sh_bits),
    .out_sticky(sh_stk)
  );

  logic [SIG_W:0] rounded;
  logic           rnd_inx, rnd_up;

  fpk_round #(.W(SIG_W)) u_round (
    .val     (sh_bits[MANT_W-1:2]),
    .guard   (sh_bits[1]),
    .rbit    (sh_bits[0]),
    .sticky  (sh_stk),
    .mode    (rnd_mode),
    .sign    (in_sign),
    .rounded (rounded),
    .inexact (rnd_inx),
    .bumped  (rnd_up)
  );

  logic carry, ovf_cond;
  assign carry    = rounded[SIG_W];
  assign exp_norm = biased + $signed({{(BX_W-1){1'b0}}, carry});
  assign ovf_cond = !is_sub && (exp_norm >= $signed(BX_W'(EXP_ONES)));

  // Next packed word and flags
  logic [WORD_W-1:0] nxt_word;
  logic              nxt_ovf, nxt_unf, nxt_inx;

  always_comb begin
    nxt_word           = '0;
    nxt_word[WORD_W-1] = in_sign;
    nxt_ovf            = 1'b0;
    nxt_unf            = 1'b0;
    nxt_inx            = 1'b0;
    case (cls)
      CLS_ZERO: ;
      CLS_INF:  nxt_word[WORD_W-2 -: EXPF_W] = EXPF_W'(EXP_ONES);
      CLS_NAN: begin
        nxt_word[WORD_W-2 -: EXPF_W] = EXPF_W'(EXP_ONES);
        nxt_word[FRAC_W-1:0]         = in_mant[MANT_W-2:2];
      end
      default: begin
        nxt_inx = rnd_inx;
        if (is_sub) begin
          nxt_word[WORD_W-2 -: EXPF_W] = EXPF_W'(rounded[FRAC_W]);
          nxt_word[FRAC_W-1:0]         = rounded[FRAC_W-1:0];
          nxt_unf                      = !rounded[FRAC_W] && (rnd_inx || uf_trap_en);
        end else if (ovf_cond) begin
          if (ovf_to_inf(md, in_sign)) begin
            nxt_word[WORD_W-2 -: EXPF_W] = EXPF_W'(EXP_ONES);
            nxt_ovf                      = 1'b1;
          end else begin
            nxt_word[WORD_W-2 -: EXPF_W] = EXPF_W'(EXP_ONES - 1);
            nxt_word[FRAC_W-1:0]         = '1;
          end
        end else begin
          nxt_word[WORD_W-2 -: EXPF_W] = exp_norm[EXPF_W-1:0];
          nxt_word[FRAC_W-1:0]         = rounded[FRAC_W-1:0];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_ovf   <= 1'b0;
      out_unf   <= 1'b0;
      out_inx   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= nxt_word;
      out_ovf <= in_valid & nxt_ovf;
      out_unf <= in_valid & nxt_unf;
      out_inx <= in_valid & nxt_inx;
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R1
  flags_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !(out_ovf || out_unf || out_inx));
  // R7
  ovf_is_inf_chk: assert property (@(posedge clk) disable iff (rst)
    out_ovf |-> (out_word[WORD_W-2:0] == {{EXPF_W{1'b1}}, {FRAC_W{1'b0}}}));
  // R7
  rz_no_inf_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls == CLS_NUM && md == RM_ZERO) |=>
      (out_word[WORD_W-2 -: EXPF_W] != EXPF_W'(EXP_ONES)));
  // R10
  unf_subnormal_chk: assert property (@(posedge clk) disable iff (rst)
    out_unf |-> (out_word[WORD_W-2 -: EXPF_W] == '0));
  // R3
  sign_kept_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_word[WORD_W-1] == $past(in_sign)));

endmodule

// File: tb/test_sp_packer.sv
module test_sp_packer;

  logic clk = 1'b0;
  logic rst;
  always #5 clk = ~clk;

  logic              in_valid;
  logic [1:0]        in_class;
  logic              in_sign;
  logic signed [9:0] in_exp;
  logic [25:0]       in_mant;
  logic              in_sticky;
  logic [1:0]        rnd_mode;
  logic              uf_trap_en;
  logic              out_valid;
  logic [31:0]       out_word;
  logic              out_ovf, out_unf, out_inx;

  sp_packer i_sp_packer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
    .in_sticky(in_sticky), .rnd_mode(rnd_mode), .uf_trap_en(uf_trap_en),
    .out_valid(out_valid), .out_word(out_word), .out_ovf(out_ovf),
    .out_unf(out_unf), .out_inx(out_inx)
  );

  int n_vec = 0;
  int n_bad = 0;

  bit          pend = 0;
  logic        e_v;
  logic [31:0] e_w;
  logic [2:0]  e_f;
  string       e_tag;

  // Arithmetic reference: returns {ovf, unf, inx, word}
  function automatic logic [34:0] ref_pack(
      input logic [1:0] c, input logic sg, input int e, input logic [25:0] m,
      input logic st, input logic [1:0] md, input logic tr, output string tag);
    logic [127:0] total, rem, half, q;
    int b, s, k;
    logic inx, up, ovf, unf;
    logic [7:0] ef;
    logic [22:0] fr;
    ovf = 0; unf = 0; inx = 0; ef = 0; fr = 0;
    if (c == 2'd0) begin tag = "R3"; return {3'b000, sg, 31'd0}; end
    if (c == 2'd2) begin tag = "R3"; return {3'b000, sg, 8'hFF, 23'd0}; end
    if (c == 2'd3) begin tag = "R4"; return {3'b000, sg, 8'hFF, m[24:2]}; end
    b = e + 127;
    s = (b <= 0) ? 1 - b : 0;
    if (s > 40) s = 40;
    k = 2 + s;
    total = (128'(m) << 60) | 128'(st);
    q     = total >> (60 + k);
    rem   = total & ((128'd1 << (60 + k)) - 128'd1);
    half  = 128'd1 << (60 + k - 1);
    inx   = (rem != 0);
    case (md)
      2'd0:    up = (rem > half) || (rem == half && q[0]);
      2'd1:    up = 1'b0;
      2'd2:    up = inx && !sg;
      default: up = inx && sg;
    endcase
    q = q + 128'(up);
    if (b > 0) begin
      tag = "R5";
      if (q >= (128'd1 << 24)) begin b = b + 1; q = q >> 1; tag = "R6"; end
      if (b >= 255) begin
        tag = "R7";
        if (md == 2'd0 || (md == 2'd2 && !sg) || (md == 2'd3 && sg)) begin
          ef = 8'hFF; ovf = 1;
        end else begin
          ef = 8'hFE; fr = '1;
        end
      end else begin
        ef = 8'(b); fr = q[22:0];
      end
    end else if (q >= (128'd1 << 23)) begin
      tag = "R9"; ef = 8'd1;
    end else begin
      fr = q[22:0];
      unf = inx || tr;
      tag = unf ? "R10" : "R8";
    end
    return {ovf, unf, inx, sg, ef, fr};
  endfunction

  task automatic check_pending();
    n_vec++;
    if (out_valid !== e_v || {out_ovf, out_unf, out_inx} !== e_f ||
        (e_v && out_word !== e_w)) begin
      n_bad++;
      $display("FAIL %s: got v=%b w=%h f=%b, expected v=%b w=%h f=%b",
               e_tag, out_valid, out_word, {out_ovf, out_unf, out_inx},
               e_v, e_w, e_f);
    end
  endtask

  task automatic drive(input logic [1:0] c, input logic sg, input int e,
                       input logic [25:0] m, input logic st, input logic [1:0] md,
                       input logic tr, input string force_tag);
    logic [34:0] r;
    string t;
    @(negedge clk);
    if (pend) check_pending();
    in_valid = 1; in_class = c; in_sign = sg; in_exp = e[9:0];
    in_mant = m; in_sticky = st; rnd_mode = md; uf_trap_en = tr;
    r = ref_pack(c, sg, e, m, st, md, tr, t);
    e_v = 1; e_w = r[31:0]; e_f = r[34:32];
    e_tag = (force_tag != "") ? force_tag : t;
    pend = 1;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    if (pend) check_pending();
    in_valid = 0;
    e_v = 0; e_f = 3'b000; e_tag = "R1 idle"; pend = 1;
  endtask

  task automatic sweep_exp(input int e);
    logic [25:0] hi [3];
    hi[0] = 26'h2000000; hi[1] = 26'h3FFFFF0; hi[2] = 26'h2AAAAA0;
    for (int p = 0; p < 3; p++)
      for (int lo = 0; lo < 16; lo++)
        for (int st = 0; st < 2; st++)
          for (int md = 0; md < 4; md++)
            for (int sg = 0; sg < 2; sg++)
              for (int tr = 0; tr < 2; tr++)
                drive(2'd1, sg[0], e, hi[p] | 26'(lo), st[0], md[1:0], tr[0], "");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst = 1; in_valid = 0; in_class = 0; in_sign = 0; in_exp = 0;
    in_mant = 0; in_sticky = 0; rnd_mode = 0; uf_trap_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    n_vec++;
    if (out_valid !== 0 || out_word !== 0 || {out_ovf, out_unf, out_inx} !== 0) begin
      n_bad++;
      $display("FAIL R1 reset: got v=%b w=%h f=%b, expected 0 0 0",
               out_valid, out_word, {out_ovf, out_unf, out_inx});
    end
    rst = 0;
    // R2: 1.0 packs to 0x3F800000
    drive(2'd1, 1'b0, 0, 26'h2000000, 1'b0, 2'd0, 1'b0, "R2");
    idle_cycle();
    // R9: largest subnormal pattern rounds into smallest normal
    drive(2'd1, 1'b0, -127, 26'h3FFFFFF, 1'b0, 2'd0, 1'b0, "");
    // R10: exact subnormal with trap enabled
    drive(2'd1, 1'b1, -130, 26'h2000000, 1'b0, 2'd1, 1'b1, "");
    idle_cycle();
    // R3 / R4: non-number classes
    for (int c = 0; c < 4; c++)
      for (int sg = 0; sg < 2; sg++)
        for (int md = 0; md < 4; md++) begin
          if (c == 1) continue;
          drive(c[1:0], sg[0], 5, 26'h3ABCDE5 ^ 26'(c * 977), 1'b1, md[1:0], 1'b1, "");
        end
    // R5..R10 sweeps around the subnormal edge and the overflow edge
    for (int e = -155; e <= -120; e++) sweep_exp(e);
    sweep_exp(-400);
    sweep_exp(-200);
    sweep_exp(-1);
    sweep_exp(0);
    for (int e = 125; e <= 129; e++) sweep_exp(e);
    idle_cycle();
    idle_cycle();
    @(negedge clk);
    if (pend) check_pending();
    pend = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule